// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends characters on an asynchronous serial line. A one-character holding register sits in front of a frame shift register. Software can write the next character while the current frame is still being sent. Each frame has a low start bit, then 8 data bits (or 9 in nine-bit mode), least significant bit first, then a high stop bit. The ninth data bit comes from a control input that is sampled when the character enters the shift register.

The shifter advances only on a one-cycle baud strobe from an external rate generator. A character pending in the holding register moves into the shift register in one of two cases:

- at once, if the shifter is idle;
- on the strobe that closes the current stop bit, if a frame is in progress. The next start bit then follows the stop bit with no idle period between them.

Two flags report status to software. The empty flag shows that the holding register may be written again. The complete flag shows that the line has gone quiet after the last frame. When the enable input is low, the output driver is released and nothing is sent.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset, `tx_line` is 1, `empty_flag` is 1 and `done_flag` is 0. `tx_line` stays 1 whenever no frame is being shifted.
- R2: A write strobe clears `empty_flag` on the next clock. When the shifter is idle and enabled, the pending character moves into the shift register on the following clock, which sets `empty_flag` again. If a write and a move happen in the same cycle, the flag stays clear.
- R3: The first `baud_tick` after a move drives the start bit (0) on `tx_line`. Each later tick drives the next data bit, least significant bit first, and the tick after the last data bit drives the stop bit (1).
- R4: With `nine_mode` = 0 a frame has 8 data bits (10 bit periods in total). With `nine_mode` = 1 it has 9 data bits, and the ninth bit is the value of `ctl_bit8` at the moment of the move (11 bit periods in total).
- R5: A character written while a frame is in progress moves only on the tick that ends the stop bit. On that same tick its start bit is driven, so no idle bit period appears between the two frames.
- R6: If nothing has been written when a frame ends, `empty_flag` stays 1 until the next write.
- R7: `done_flag` is set on the tick that ends the stop bit period when no character is pending. It is cleared by a `done_clr` strobe or by the move of a new character.
- R8: A write while `empty_flag` is 0 replaces the pending character. The frame currently on the line is not changed, and only the last character written is sent.
- R9: While `tx_en` is 0, `tx_oe` is 0, `tx_line` is 1, no frame starts and a pending character is kept. It is sent after `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| nine_mode | input | 1 | 1 selects 9 data bits per frame |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W (8) | Character to write |
| ctl_bit8 | input | 1 | Ninth data bit, sampled when a character moves |
| baud_tick | input | 1 | One-cycle bit-period strobe |
| done_clr | input | 1 | Clears the complete flag (write one to clear) |
| tx_line | output | 1 | Serial data output |
| tx_oe | output | 1 | Output driver enable |
| empty_flag | output | 1 | Holding register may be written |
| done_flag | output | 1 | Transmission complete, line quiet |

## Verification
The assertions take three things for granted about the inputs:

- `baud_tick` lasts one clock cycle per bit period.
- `nine_mode` changes only while the shifter is idle.
- `ctl_bit8` is held steady from the write until the move.

The stimulus meets these conditions as follows. Ticks come from a fixed divider. The mode is changed only after the line has drained. In nine-bit sequences, each character's ninth bit is set up only after `empty_flag` shows that the previous character has moved. The one deliberate exception is the overwrite sequence: its write lands on the clock of a move, to exercise the case where a write and a move happen in the same cycle.

// File: rtl/sertx_pkg.sv
// Package: shared types for the double-buffered serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package sertx_pkg;

    // Shifter state: idle, loaded and waiting for the first tick, or shifting.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_RUN   = 2'd2
    } tx_state_e;

endpackage

// File: rtl/sertx_hold.sv
// Module: sertx_hold
// Keeps the one pending character. A write overwrites it and marks it
// pending. A move into the shifter clears the pending mark unless a write
// arrives in the same cycle.
// Assumes: load is asserted only while pend_o is 1.
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic              pend_o,
    output logic [DATA_W-1:0] data_o
);

    logic              pend_q;
    logic [DATA_W-1:0] data_q;

    // Capture written data and track whether a character waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            data_q <= '0;
        end else if (wr_stb) begin
            pend_q <= 1'b1;
            data_q <= wr_data;
        end else if (load) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign data_o = data_q;

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !load && !wr_stb) |=> (pend_q && $stable(data_q))); // R8

    AST_WR_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> pend_q); // R2

endmodule

// File: rtl/sertx_shift.sv
// Module: sertx_shift
// Builds a frame from the pending character and shifts it onto the line,
// one bit per baud tick. It reloads from the holding register either at
// once when idle, or on the tick that ends the stop bit.
// Assumes: baud_tick lasts one cycle; nine_mode changes only while idle.
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              nine_mode,
    input  logic              bit8,
    input  logic              pend,
    input  logic [DATA_W-1:0] data,
    output logic              load,
    output logic              done_evt,
    output logic              line
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int CW      = $clog2(FRAME_W + 1);
    localparam logic [CW-1:0] LEN_STD  = CW'(DATA_W + 2);
    localparam logic [CW-1:0] LEN_WIDE = CW'(DATA_W + 3);

    tx_state_e          st_q;
    logic [FRAME_W-1:0] sr_q;
    logic [CW-1:0]      cnt_q;
    logic [CW-1:0]      len_q;
    logic               line_q;

    logic [FRAME_W-1:0] frame;
    logic [CW-1:0]      frame_len;
    logic               end_tick;

    // Assemble the next frame: start low, data, optional ninth bit, stop high.
    always_comb begin
        frame              = '1;
        frame[0]           = 1'b0;
        frame[DATA_W:1]    = data;
        frame[DATA_W+1]    = nine_mode ? bit8 : 1'b1;
        frame_len          = nine_mode ? LEN_WIDE : LEN_STD;
    end

    // Find the tick that ends the stop bit and decide on a reload.
    always_comb begin
        end_tick = en && tick && (st_q == TX_RUN) && (cnt_q == len_q);
        load     = en && pend && ((st_q == TX_IDLE) || end_tick);
        done_evt = end_tick && !pend;
    end

    // Sequence loading and shifting of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TX_IDLE;
            sr_q   <= '1;
            cnt_q  <= '0;
            len_q  <= LEN_STD;
            line_q <= 1'b1;
        end else if (!en) begin
            st_q   <= TX_IDLE;
            cnt_q  <= '0;
            line_q <= 1'b1;
        end else if (load && (st_q == TX_IDLE)) begin
            st_q  <= TX_ARMED;
            sr_q  <= frame;
            cnt_q <= '0;
            len_q <= frame_len;
        end else if (load) begin
            st_q   <= TX_RUN;
            line_q <= frame[0];
            sr_q   <= {1'b1, frame[FRAME_W-1:1]};
            cnt_q  <= CW'(1);
            len_q  <= frame_len;
        end else if (end_tick) begin
            st_q   <= TX_IDLE;
            line_q <= 1'b1;
        end else if (tick && (st_q != TX_IDLE)) begin
            st_q   <= TX_RUN;
            line_q <= sr_q[0];
            sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign line = line_q;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_IDLE) |-> line_q); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && st_q == TX_ARMED) |=> !line_q); // R3

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (line_q && st_q == TX_IDLE)); // R9

    AST_NO_EARLY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_RUN && !(tick && cnt_q == len_q)) |-> !load); // R5

    AST_B2B_START: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st_q == TX_RUN) |=> (!line_q && st_q == TX_RUN)); // R5

endmodule

// File: rtl/sertx_flags.sv
// Module: sertx_flags
// Keeps the status flags that software sees. The empty flag clears on a
// write and sets on a move. The complete flag sets when a frame ends with
// nothing pending and clears on a clear strobe or a move.
// Assumes: done_evt and load are never both asserted.
module sertx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic load,
    input  logic done_evt,
    input  logic done_clr,
    output logic empty_flag,
    output logic done_flag
);

    logic empty_q;
    logic done_q;

    // Empty flag: a write has priority over a move in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else if (wr_stb) begin
            empty_q <= 1'b0;
        end else if (load) begin
            empty_q <= 1'b1;
        end
    end

    // Complete flag: the end-of-frame event has priority over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (done_evt) begin
            done_q <= 1'b1;
        end else if (done_clr || load) begin
            done_q <= 1'b0;
        end
    end

    assign empty_flag = empty_q;
    assign done_flag  = done_q;

    AST_WR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !empty_q); // R2

    AST_MOVE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_stb) |=> empty_q); // R2

    AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_clr || load) && !done_evt) |=> !done_q); // R7

    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> done_q); // R7

endmodule

// File: rtl/sertx_dbuf.sv
// Module: sertx_dbuf (top)
// Double-buffered asynchronous serial transmitter. It connects the holding
// register, the frame shifter and the status flags.
// Assumes: baud_tick comes from an external rate generator in this clock
// domain, one cycle wide.
module sertx_dbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              nine_mode,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ctl_bit8,
    input  logic              baud_tick,
    input  logic              done_clr,
    output logic              tx_line,
    output logic              tx_oe,
    output logic              empty_flag,
    output logic              done_flag
);

    logic              pend;
    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              done_evt;

    sertx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .load    (load),
        .pend_o  (pend),
        .data_o  (hold_data)
    );

    sertx_shift #(.DATA_W(DATA_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .tick      (baud_tick),
        .nine_mode (nine_mode),
        .bit8      (ctl_bit8),
        .pend      (pend),
        .data      (hold_data),
        .load      (load),
        .done_evt  (done_evt),
        .line      (tx_line)
    );

    sertx_flags flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .load       (load),
        .done_evt   (done_evt),
        .done_clr   (done_clr),
        .empty_flag (empty_flag),
        .done_flag  (done_flag)
    );

    // Drive the output only while enabled.
    assign tx_oe = tx_en;

    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        empty_flag == !pend); // R2

endmodule

// File: tb/sertx_dbuf_tb_top.sv
// Scoreboard bench: the driver tasks queue the expected frames, and the
// monitor, running in step with the baud ticks, decodes the line and
// compares each frame with the queue.
module sertx_dbuf_tb_top;

    localparam int DIV = 8;

    typedef struct {
        logic [8:0] v;
        bit         gap0;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       nine_mode = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ctl_bit8 = 1'b0;
    logic       baud_tick = 1'b0;
    logic       done_clr = 1'b0;
    logic       tx_line;
    logic       tx_oe;
    logic       empty_flag;
    logic       done_flag;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    exp_t exp_q[$];

    int         mon_st = 0;
    int         mon_bits = 0;
    int         mon_n = 8;
    int         idle_ticks = 0;
    int         gap_seen = 0;
    logic [8:0] mon_val = '0;

    always #10 clk = ~clk;

    sertx_dbuf #(.DATA_W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .nine_mode  (nine_mode),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .ctl_bit8   (ctl_bit8),
        .baud_tick  (baud_tick),
        .done_clr   (done_clr),
        .tx_line    (tx_line),
        .tx_oe      (tx_oe),
        .empty_flag (empty_flag),
        .done_flag  (done_flag)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor step: called just after each tick has been applied.
    task automatic mon_step();
        exp_t e;
        case (mon_st)
            0: begin
                if (tx_line == 1'b0 && tx_oe) begin
                    gap_seen = idle_ticks;
                    mon_n    = nine_mode ? 9 : 8;
                    mon_bits = 0;
                    mon_val  = '0;
                    mon_st   = 1;
                end else begin
                    idle_ticks++;
                end
            end
            1: begin
                mon_val[mon_bits] = tx_line;
                mon_bits++;
                if (mon_bits == mon_n) mon_st = 2;
            end
            default: begin
                chk(32'(tx_line), 32'd1, "R3 stop bit");
                if (exp_q.size() == 0) begin
                    chk(32'(mon_val), 32'h1ff, "R9 unexpected frame");
                end else begin
                    e = exp_q.pop_front();
                    chk(32'(mon_val), 32'(e.v), mon_n == 9 ? "R4 nine-bit frame" : "R3 frame data");
                    if (e.gap0) chk(32'(gap_seen), 32'd0, "R5 no idle gap");
                end
                idle_ticks = 0;
                mon_st     = 0;
            end
        endcase
    endtask

    // Baud strobe generator and monitor.
    initial begin
        forever begin
            repeat (DIV - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            mon_step();
        end
    end

    task automatic raw_write(input logic [7:0] d);
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    // Driver: wait until the holding register is free, write, queue the result.
    task automatic send(input logic [7:0] d, input logic b8, input bit gap0);
        exp_t e;
        while (!empty_flag) @(negedge clk);
        ctl_bit8 = b8;
        e.v    = nine_mode ? {b8, d} : {1'b0, d};
        e.gap0 = gap0;
        exp_q.push_back(e);
        raw_write(d);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || mon_st != 0) @(negedge clk);
        repeat (2 * DIV + 2) @(negedge clk);
    endtask

    initial begin
        exp_t e;
        repeat (5) @(negedge clk);
        chk(32'(tx_line), 32'd1, "R1 reset line");
        chk(32'(empty_flag), 32'd1, "R1 reset empty");
        chk(32'(done_flag), 32'd0, "R1 reset done");
        rst_n = 1'b1;
        tx_en = 1'b1;
        @(negedge clk);

        // Idle write: empty clears, then sets again once the character moves.
        send(8'hA5, 1'b0, 1'b0);
        chk(32'(empty_flag), 32'd0, "R2 empty clears on write");
        @(negedge clk);
        chk(32'(empty_flag), 32'd1, "R2 empty sets on move");
        drain();
        chk(32'(done_flag), 32'd1, "R7 done after frame");
        chk(32'(empty_flag), 32'd1, "R6 empty stays set");
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk(32'(done_flag), 32'd0, "R7 done cleared by strobe");

        // Back-to-back 8-bit frames.
        send(8'h3C, 1'b0, 1'b0);
        send(8'h81, 1'b0, 1'b1);
        chk(32'(empty_flag), 32'd0, "R2 pending during frame");
        send(8'h00, 1'b0, 1'b1);
        send(8'hFF, 1'b0, 1'b1);
        drain();
        chk(32'(done_flag), 32'd1, "R7 done after burst");

        // A new frame clears the complete flag.
        send(8'h55, 1'b0, 1'b0);
        @(negedge clk);
        chk(32'(done_flag), 32'd0, "R7 done cleared by new frame");
        chk(32'(empty_flag), 32'd1, "R2 moved");
        drain();

        // Nine-bit mode, back to back.
        nine_mode = 1'b1;
        send(8'h12, 1'b1, 1'b0);
        send(8'hF0, 1'b0, 1'b1);
        send(8'h00, 1'b1, 1'b1);
        drain();
        nine_mode = 1'b0;
        @(negedge clk);

        // Overwrite of the pending character.
        send(8'h11, 1'b0, 1'b0);
        raw_write(8'h22);
        repeat (2 * DIV) @(negedge clk);
        raw_write(8'h33);
        chk(32'(empty_flag), 32'd0, "R8 still pending after overwrite");
        e.v    = 9'h033;
        e.gap0 = 1'b1;
        exp_q.push_back(e);
        drain();

        // Disabled: nothing is sent and the pending character is kept.
        tx_en = 1'b0;
        @(negedge clk);
        chk(32'(tx_oe), 32'd0, "R9 output released");
        raw_write(8'h6B);
        for (int i = 0; i < 12 * DIV; i++) begin
            @(negedge clk);
            if (tx_line !== 1'b1) chk(32'(tx_line), 32'd1, "R9 line quiet when off");
        end
        chk(32'(tx_line), 32'd1, "R9 line high when off");
        chk(32'(empty_flag), 32'd0, "R9 pending kept");
        e.v    = 9'h06B;
        e.gap0 = 1'b0;
        exp_q.push_back(e);
        tx_en = 1'b1;
        drain();
        chk(32'(tx_oe), 32'd1, "R9 output driven");
        chk(32'(exp_q.size()), 32'd0, "R3 all frames seen");

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule